// File: doc/BRIEF.md
# Byte-Slot GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller in which each pin owns a whole byte in every register bank. Software changes one pin with a single byte store and never needs a read-modify-write. Only bit 0 of each byte carries meaning. Banks hold the direction, output value, sampled input level and the interrupt settings of each pin. The bank that selects a pin as input or output resets to input.

Each pin has an interrupt detector. Its trigger is chosen by three separate bits: polarity, edge select and dual-edge. It can fire on a low level, a high level, a falling edge, a rising edge or on both edges. Pad levels pass through a two-flop synchroniser before detection. Edge events latch a sticky status bit that software clears by writing 1 to the pin's clear byte. Level status simply follows the pin. A status bit may be set on a masked pin. Only pins whose status and enable are both set drive the single registered interrupt output.

Top module: `byte_gpio`

## Requirements
- R1: After synchronous reset every pin is an input (pin_oe all 0), pin_out is all 0, every enable, polarity, edge and dual bit is 0, and irq_out is 0.
- R2: Pin k is found at bank base + k. The bank bases are: direction 0x800, output 0x900, input 0xA00, enable 0xB00, polarity 0xC00, edge 0xD00, clear 0xE00, status 0xF00 and dual-edge 0xF80. Writes store wdata bit 0. bus_rdata is registered: it is valid one cycle after bus_addr is presented, with bits 7:1 always 0.
- R3: Writing 0 to a pin's direction byte makes pin_oe[k] 1, and pin_out[k] then shows the pin's output byte. Writing 1 sets pin_oe[k] to 0. The direction byte reads back as 1 for input and 0 for output.
- R4: The input byte of pin k returns the level of pin_in[k] after a two-flop synchroniser.
- R5: With edge=0, status follows the synchronised level: it is 1 while the pin is low if polarity=0, and 1 while the pin is high if polarity=1.
- R6: With edge=1 and dual=0, a rising edge sets status if polarity=1 and a falling edge sets it if polarity=0. The status then stays 1 until a write with bit 0 = 1 to the pin's clear byte.
- R7: With edge=1 and dual=1, either edge sets status, whatever the polarity.
- R8: A qualifying edge in the same cycle as a clear write leaves status at 1.
- R9: irq_out is 1 exactly when some pin had both status and enable set one cycle earlier. A status bit may read 1 while its enable is 0.
- R10: Reads return 0 for a bank base below 0x800 and for any slot index at or above NPIN. Writes to the input and status banks, and to unmapped slots, have no effect.
- R11: A clear write to a pin in level mode does not remove its status while the active level persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register slot |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_wdata | input | 8 | Write data; only bit 0 is stored |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| pin_in | input | NPIN | Raw pad levels |
| pin_out | output | NPIN | Output values |
| pin_oe | output | NPIN | Output enables, 1 = drive |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
The bench builds the controller with NPIN = 6. This is not a power of two, so slots 6 and 7 fall inside the decoded index width of each bank but are still unmapped. Reads and writes to them show whether the range check or only the index truncation guards the banks. The six pins are enough to run level, single-edge and dual-edge modes side by side on separate pins. They also cover a masked pin whose status is set.

// File: rtl/byte_gpio_pkg.sv
`timescale 1ns/1ps
package byte_gpio_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;
  // bank selector = address bits 11:8
  localparam logic [3:0] BK_DIR  = 4'h8;
  localparam logic [3:0] BK_OUT  = 4'h9;
  localparam logic [3:0] BK_IN   = 4'hA;
  localparam logic [3:0] BK_EN   = 4'hB;
  localparam logic [3:0] BK_POL  = 4'hC;
  localparam logic [3:0] BK_EDGE = 4'hD;
  localparam logic [3:0] BK_CLR  = 4'hE;
  localparam logic [3:0] BK_HI   = 4'hF; // status low half, dual-edge upper half
endpackage

// File: rtl/byte_gpio_sync.sv
`timescale 1ns/1ps
module byte_gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      lvl_o  <= '0;
      prev_o <= '0;
    end else begin
      meta_q <= raw_i;
      lvl_o  <= meta_q;
      prev_o <= lvl_o;
    end
  end

  // R4: the synchronised level is the raw input two cycles late
  sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (lvl_o == $past(raw_i, 2)));
endmodule

// File: rtl/byte_gpio_irq_cell.sv
`timescale 1ns/1ps
module byte_gpio_irq_cell (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  input  logic prev_i,
  input  logic pol_i,
  input  logic edge_i,
  input  logic dual_i,
  input  logic clr_i,
  output logic status_o
);
  logic rise, fall, edge_hit, status_d;

  always_comb begin
    rise = lvl_i & ~prev_i;
    fall = ~lvl_i & prev_i;
    if (dual_i)     edge_hit = rise | fall;
    else if (pol_i) edge_hit = rise;
    else            edge_hit = fall;
    if (edge_i) status_d = edge_hit | (status_o & ~clr_i);
    else        status_d = (lvl_i == pol_i);
  end

  always_ff @(posedge clk) begin
    if (rst) status_o <= 1'b0;
    else     status_o <= status_d;
  end

  // R6
  sticky_status_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_i && status_o && !clr_i) |=> status_o);
  // R5
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!edge_i && (lvl_i == pol_i)) |=> status_o);
  // R8
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_i && dual_i && (lvl_i != prev_i) && clr_i) |=> status_o);
endmodule

// File: rtl/byte_gpio.sv
`timescale 1ns/1ps
module byte_gpio
  import byte_gpio_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [11:0]       bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic              irq_out
);
  localparam int IDX_W = (NPIN > 1) ? $clog2(NPIN) : 1;

  logic [3:0]       bank;
  logic [7:0]       lane;
  logic             lane_ok;
  logic [IDX_W-1:0] lane_idx;
  logic             hi_upper;
  logic             rd_map;
  logic             rd_bit;
  logic [NPIN-1:0]  en_q, pol_q, edge_q, dual_q;
  logic [NPIN-1:0]  lvl, prev, status, clr_vec;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata[7:1];

  // address decode
  always_comb begin
    bank     = bus_addr[11:8];
    hi_upper = (bank == BK_HI) && bus_addr[7];
    lane     = hi_upper ? {1'b0, bus_addr[6:0]} : bus_addr[7:0];
    lane_ok  = (int'(lane) < NPIN);
    lane_idx = lane[IDX_W-1:0];
    rd_map   = lane_ok && bank[3];
  end

  // per-pin configuration bytes
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe  <= '0;
      pin_out <= '0;
      en_q    <= '0;
      pol_q   <= '0;
      edge_q  <= '0;
      dual_q  <= '0;
    end else if (bus_wr && lane_ok) begin
      unique case (bank)
        BK_DIR:  pin_oe[lane_idx]  <= ~bus_wdata[0];
        BK_OUT:  pin_out[lane_idx] <= bus_wdata[0];
        BK_EN:   en_q[lane_idx]    <= bus_wdata[0];
        BK_POL:  pol_q[lane_idx]   <= bus_wdata[0];
        BK_EDGE: edge_q[lane_idx]  <= bus_wdata[0];
        BK_HI:   if (hi_upper) dual_q[lane_idx] <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  // clear pulses
  always_comb begin
    for (int k = 0; k < NPIN; k++) begin
      clr_vec[k] = bus_wr && lane_ok && (bank == BK_CLR) && bus_wdata[0]
                   && (lane_idx == IDX_W'(k));
    end
  end

  byte_gpio_sync #(.W(NPIN)) sync_i (
    .clk    (clk),
    .rst    (rst),
    .raw_i  (pin_in),
    .lvl_o  (lvl),
    .prev_o (prev)
  );

  for (genvar k = 0; k < NPIN; k++) begin : g_cell
    byte_gpio_irq_cell cell_i (
      .clk      (clk),
      .rst      (rst),
      .lvl_i    (lvl[k]),
      .prev_i   (prev[k]),
      .pol_i    (pol_q[k]),
      .edge_i   (edge_q[k]),
      .dual_i   (dual_q[k]),
      .clr_i    (clr_vec[k]),
      .status_o (status[k])
    );
  end

  // read mux
  always_comb begin
    rd_bit = 1'b0;
    if (lane_ok) begin
      unique case (bank)
        BK_DIR:  rd_bit = ~pin_oe[lane_idx];
        BK_OUT:  rd_bit = pin_out[lane_idx];
        BK_IN:   rd_bit = lvl[lane_idx];
        BK_EN:   rd_bit = en_q[lane_idx];
        BK_POL:  rd_bit = pol_q[lane_idx];
        BK_EDGE: rd_bit = edge_q[lane_idx];
        BK_HI:   rd_bit = hi_upper ? dual_q[lane_idx] : status[lane_idx];
        default: rd_bit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      bus_rdata <= {7'b0, rd_bit};
      irq_out   <= |(status & en_q);
    end
  end

  // R3
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && lane_ok && (bank == BK_DIR) && !bus_wdata[0]) |=> pin_oe[$past(lane_idx)]);
  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_map |=> (bus_rdata == 8'h00));
  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq_out);
  // R2
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[7:1] == 7'b0);
endmodule

// File: tb/byte_gpio_tb_top.sv
`timescale 1ns/1ps
module byte_gpio_tb_top;
  localparam int NP = 6;

  typedef struct {
    logic [7:0] exp;
    string      req;
    logic [11:0] addr;
  } rd_item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [11:0]   bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  rd_item_t sb_q[$];

  always #10 clk = ~clk; // 50 MHz

  byte_gpio #(.NPIN(NP)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  // monitor: pops expected read data once the registered result appears
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      rd_item_t it;
      it = sb_q.pop_front();
      checks++;
      if (bus_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s read 0x%03h actual=0x%02h expected=0x%02h",
                 it.req, it.addr, bus_rdata, it.exp);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] e, input string req);
    rd_item_t it;
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    it.exp = e; it.req = req; it.addr = a;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string req, input string what);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, e);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    chk(32'(pin_oe), 0, "R1", "pin_oe");
    chk(32'(pin_out), 0, "R1", "pin_out");
    chk(32'(irq_out), 0, "R1", "irq_out");
    rd(12'h800, 8'h01, "R1");
    rd(12'hB02, 8'h00, "R1");

    // R3 output sequencing, R2 bit0-only storage
    wr(12'h902, 8'h01);
    wr(12'h802, 8'h00);
    chk(32'(pin_oe), 32'h04, "R3", "pin_oe after dir=0");
    chk(32'(pin_out[2]), 1, "R3", "pin_out[2]");
    rd(12'h902, 8'h01, "R2");
    rd(12'h802, 8'h00, "R3");
    wr(12'h802, 8'hFF);
    chk(32'(pin_oe), 0, "R3", "pin_oe after dir=1");
    rd(12'h802, 8'h01, "R2");
    wr(12'hC05, 8'hFE);
    rd(12'hC05, 8'h00, "R2");

    // R4 input sampling
    pin_in = 6'b101001;
    idle(5);
    rd(12'hA00, 8'h01, "R4");
    rd(12'hA01, 8'h00, "R4");
    rd(12'hA05, 8'h01, "R4");
    wr(12'hA01, 8'h01);
    rd(12'hA01, 8'h00, "R10");

    // R10 unmapped slots
    rd(12'h700, 8'h00, "R10");
    wr(12'h806, 8'h00);
    chk(32'(pin_oe), 0, "R10", "pin_oe after unmapped write");
    rd(12'h806, 8'h00, "R10");
    rd(12'hF86, 8'h00, "R10");
    pin_in = '0;
    idle(5);

    // R9 masked status (pin3 default level-low with low input)
    rd(12'hF03, 8'h01, "R9");
    chk(32'(irq_out), 0, "R9", "irq with all enables 0");

    // R5 level-high on pin1, R11 clear ignored while level holds
    wr(12'hC01, 8'h01);
    wr(12'hB01, 8'h01);
    idle(2);
    chk(32'(irq_out), 0, "R5", "irq level-high pin low");
    pin_in[1] = 1'b1;
    idle(5);
    chk(32'(irq_out), 1, "R5", "irq level-high pin high");
    wr(12'hE01, 8'h01);
    rd(12'hF01, 8'h01, "R11");
    pin_in[1] = 1'b0;
    idle(5);
    rd(12'hF01, 8'h00, "R5");
    chk(32'(irq_out), 0, "R5", "irq after level drops");

    // R6 rising edge on pin0
    wr(12'hC00, 8'h01);
    wr(12'hD00, 8'h01);
    wr(12'hE00, 8'h01);
    wr(12'hB00, 8'h01);
    rd(12'hF00, 8'h00, "R6");
    pin_in[0] = 1'b1;
    idle(5);
    chk(32'(irq_out), 1, "R6", "irq on rising edge");
    pin_in[0] = 1'b0;
    idle(5);
    rd(12'hF00, 8'h01, "R6");
    wr(12'hE00, 8'h01);
    idle(2);
    rd(12'hF00, 8'h00, "R6");
    chk(32'(irq_out), 0, "R6", "irq after clear");
    // falling mode
    wr(12'hC00, 8'h00);
    pin_in[0] = 1'b1;
    idle(5);
    rd(12'hF00, 8'h00, "R6");
    pin_in[0] = 1'b0;
    idle(5);
    rd(12'hF00, 8'h01, "R6");
    wr(12'hE00, 8'h01);

    // R7 dual edge on pin4 with polarity 0
    wr(12'hD04, 8'h01);
    wr(12'hF84, 8'h01);
    wr(12'hE04, 8'h01);
    rd(12'hF04, 8'h00, "R7");
    pin_in[4] = 1'b1;
    idle(5);
    rd(12'hF04, 8'h01, "R7");
    wr(12'hE04, 8'h01);
    rd(12'hF04, 8'h00, "R7");
    pin_in[4] = 1'b0;
    idle(5);
    rd(12'hF04, 8'h01, "R7");
    rd(12'hF84, 8'h01, "R2");

    // R8 clear in the same cycle as a rising edge on pin0
    wr(12'hC00, 8'h01);
    wr(12'hE00, 8'h01);
    rd(12'hF00, 8'h00, "R8");
    @(negedge clk);
    pin_in[0] = 1'b1;
    @(negedge clk);
    wr(12'hE00, 8'h01);
    rd(12'hF00, 8'h01, "R8");
    wr(12'hF00, 8'h00);
    rd(12'hF00, 8'h01, "R10");
    wr(12'hE00, 8'h01);
    rd(12'hF00, 8'h00, "R6");

    // R9 enable gating on pin3
    chk(32'(irq_out), 0, "R9", "irq before enabling pin3");
    wr(12'hB03, 8'h01);
    idle(2);
    chk(32'(irq_out), 1, "R9", "irq with pin3 enabled");
    wr(12'hB03, 8'h00);
    idle(2);
    chk(32'(irq_out), 0, "R9", "irq after masking pin3");

    idle(2);
    done = 1'b1;
    report();
  end
endmodule